// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This block sits between a memory controller's command scheduler and the command pins of a single-data-rate SDRAM, and it owns the clock-enable (CKE) pin. When the scheduler asks for a low-power period, the block looks at whether any bank is open. With every bank closed it lowers CKE for power-down. With a bank open it lowers CKE for clock-suspend. While the memory is in either state, the block holds the scheduler off with a ready signal and drives harmless codes on the command lines.

On exit the block raises CKE and drives no-operation codes for a fixed recovery window before the scheduler's commands reach the pins again. The window for power-down is longer than the one for clock-suspend. The memory does no refreshing while in power-down, so a residency timer forces an exit a set margin before the refresh period runs out. Every timing value is a parameter counted in controller clock cycles.

Top module: `cke_power_seq`

## Requirements
- R1: After reset, `pwr_state` is 2'b00 (active), `mem_cke` is 1 and `sch_ready` is 1.
- R2: In the active state with no accepted entry, `sch_ready` is 1 and the command pins copy the scheduler command in the same cycle. The command pins are {cs_n, ras_n, cas_n, we_n}.
- R3: An entry request is accepted when it arrives in the active state with `any_bank_open`=0 and `burst_busy`=0. In the accepting cycle, `sch_ready` is 0 and the pins carry no-operation (4'b0111). From the next cycle, `mem_cke` is 0 and `pwr_state` is 2'b01 (power-down).
- R4: An entry request in the active state with `any_bank_open`=1 is accepted whatever the value of `burst_busy`. From the next cycle, `mem_cke` is 0 and `pwr_state` is 2'b10 (clock-suspend).
- R5: An entry request with `any_bank_open`=0 and `burst_busy`=1 is held off. The block stays active with `mem_cke`=1, `sch_ready`=1, and the scheduler command passed through to the pins.
- R6: In power-down, the pins carry deselect (4'b1111) and `sch_ready` is 0, whatever the scheduler drives.
- R7: In clock-suspend, the pins carry no-operation (4'b0111) and `sch_ready` is 0. An exit request gives exactly one exiting cycle and then the active state.
- R8: An exit request in power-down sets `mem_cke` to 1 and `pwr_state` to 2'b11 (exiting) in the next cycle. The block stays in that state, driving no-operation with `sch_ready`=0, for CKS_CYC+CK_CYC cycles and then returns to active.
- R9: Power-down lasts at most REF_LIMIT-REF_MARGIN cycles. When no exit is requested, `pd_timeout` pulses for one cycle on the last power-down cycle, and the exit sequence of R8 follows.
- R10: Entry requests have no effect outside the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_enter_req | input | 1 | Request to enter a low-power state |
| lp_exit_req | input | 1 | Request to leave the low-power state |
| any_bank_open | input | 1 | High when at least one bank is open |
| burst_busy | input | 1 | High while a read or write burst is running |
| sch_cs_n | input | 1 | Scheduler chip select, active low |
| sch_ras_n | input | 1 | Scheduler row strobe, active low |
| sch_cas_n | input | 1 | Scheduler column strobe, active low |
| sch_we_n | input | 1 | Scheduler write enable, active low |
| sch_ready | output | 1 | High when the scheduler's command reaches the pins |
| mem_cke | output | 1 | Clock-enable pin |
| mem_cs_n | output | 1 | Chip-select pin |
| mem_ras_n | output | 1 | Row-strobe pin |
| mem_cas_n | output | 1 | Column-strobe pin |
| mem_we_n | output | 1 | Write-enable pin |
| pwr_state | output | 2 | 00 active, 01 power-down, 10 clock-suspend, 11 exiting |
| pd_timeout | output | 1 | One-cycle pulse when residency forces an exit |

## Verification
The bench counts the power-down residency cycle by cycle when no exit is requested. A timer that is off by one would show a residency of 55 or 57 cycles instead of 56, or a timeout pulse on the wrong cycle. The bench also counts the exiting cycles after each kind of exit: a design that used the long window after suspend, or skipped the window after power-down, would hand the pins back to the scheduler too early or too late. It checks the accepting cycle itself, where a leak of the scheduler command would put a real command on the pins while CKE falls. It tries entry with a burst running, both with and without an open bank, to catch a gate that blocks the wrong case.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'b00,
    PS_PDOWN   = 2'b01,
    PS_SUSPEND = 2'b10,
    PS_EXITING = 2'b11
  } pstate_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t CMD_NOP   = 4'b0111;
  localparam pin_cmd_t CMD_DESEL = 4'b1111;

  // cycles spent in the exiting state after power-down (never zero)
  function automatic int unsigned pd_exit_len(int unsigned cks, int unsigned ck);
    int unsigned s;
    s = cks + ck;
    return (s == 0) ? 1 : s;
  endfunction

  // largest number of power-down cycles before a forced exit (at least one)
  function automatic int unsigned force_point(int unsigned limit, int unsigned margin);
    return (margin >= limit) ? 1 : (limit - margin);
  endfunction

endpackage

// File: rtl/cke_mode_fsm.sv
module cke_mode_fsm
  import cke_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enter_req,
  input  logic    exit_req,
  input  logic    bank_open,
  input  logic    burst_busy,
  input  logic    force_exit,
  input  logic    exit_done,
  output pstate_t st,
  output logic    cke,
  output logic    enter_ok,
  output logic    exit_start,
  output logic    exit_from_pd
);

  pstate_t st_nx;

  assign enter_ok     = (st == PS_ACTIVE) && enter_req && (bank_open || !burst_busy);
  assign exit_start   = ((st == PS_PDOWN) && (exit_req || force_exit)) ||
                        ((st == PS_SUSPEND) && exit_req);
  assign exit_from_pd = (st == PS_PDOWN);

  always_comb begin
    st_nx = st;
    case (st)
      PS_ACTIVE:  if (enter_ok) st_nx = bank_open ? PS_SUSPEND : PS_PDOWN;
      PS_PDOWN:   if (exit_start) st_nx = PS_EXITING;
      PS_SUSPEND: if (exit_start) st_nx = PS_EXITING;
      PS_EXITING: if (exit_done) st_nx = PS_ACTIVE;
      default:    st_nx = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= PS_ACTIVE;
      cke <= 1'b1;
    end else begin
      st <= st_nx;
      if (enter_ok)        cke <= 1'b0;
      else if (exit_start) cke <= 1'b1;
    end
  end

endmodule

// File: rtl/cke_residency_timer.sv
module cke_residency_timer #(
  parameter int unsigned FORCE_AT = 56,
  parameter int unsigned W        = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);

  logic [W-1:0] cnt;

  assign expire = run && (cnt == W'(FORCE_AT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (!done) cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/cke_cmd_gate.sv
module cke_cmd_gate
  import cke_seq_pkg::*;
(
  input  pstate_t  st,
  input  logic     enter_ok,
  input  pin_cmd_t sch_cmd,
  output pin_cmd_t pin_cmd,
  output logic     ready
);

  assign ready = (st == PS_ACTIVE) && !enter_ok;

  always_comb begin
    if (ready)               pin_cmd = sch_cmd;
    else if (st == PS_PDOWN) pin_cmd = CMD_DESEL;
    else                     pin_cmd = CMD_NOP;
  end

endmodule

// File: rtl/cke_power_seq.sv
module cke_power_seq
  import cke_seq_pkg::*;
#(
  parameter int unsigned REF_LIMIT  = 64,
  parameter int unsigned REF_MARGIN = 8,
  parameter int unsigned CKS_CYC    = 2,
  parameter int unsigned CK_CYC     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_enter_req,
  input  logic       lp_exit_req,
  input  logic       any_bank_open,
  input  logic       burst_busy,
  input  logic       sch_cs_n,
  input  logic       sch_ras_n,
  input  logic       sch_cas_n,
  input  logic       sch_we_n,
  output logic       sch_ready,
  output logic       mem_cke,
  output logic       mem_cs_n,
  output logic       mem_ras_n,
  output logic       mem_cas_n,
  output logic       mem_we_n,
  output logic [1:0] pwr_state,
  output logic       pd_timeout
);

  localparam int unsigned FORCE_AT = force_point(REF_LIMIT, REF_MARGIN);
  localparam int unsigned PD_LEN   = pd_exit_len(CKS_CYC, CK_CYC);
  localparam int unsigned RES_W    = $clog2(FORCE_AT + 1);
  localparam int unsigned LEN_W    = $clog2(PD_LEN + 1);

  pstate_t    st;
  logic       enter_ok, exit_start, exit_from_pd, exit_done, force_exit;
  pin_cmd_t   sch_cmd, pin_cmd;
  logic [LEN_W-1:0] exit_len_m1;

  assign sch_cmd     = '{cs_n: sch_cs_n, ras_n: sch_ras_n, cas_n: sch_cas_n, we_n: sch_we_n};
  assign exit_len_m1 = exit_from_pd ? LEN_W'(PD_LEN - 1) : '0;

  cke_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_req   (lp_enter_req),
    .exit_req    (lp_exit_req),
    .bank_open   (any_bank_open),
    .burst_busy  (burst_busy),
    .force_exit  (force_exit),
    .exit_done   (exit_done),
    .st          (st),
    .cke         (mem_cke),
    .enter_ok    (enter_ok),
    .exit_start  (exit_start),
    .exit_from_pd(exit_from_pd)
  );

  cke_residency_timer #(.FORCE_AT(FORCE_AT), .W(RES_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (enter_ok),
    .run   (st == PS_PDOWN),
    .expire(force_exit)
  );

  cke_exit_timer #(.W(LEN_W)) u_exit (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (exit_start),
    .load_val(exit_len_m1),
    .done    (exit_done)
  );

  cke_cmd_gate u_gate (
    .st      (st),
    .enter_ok(enter_ok),
    .sch_cmd (sch_cmd),
    .pin_cmd (pin_cmd),
    .ready   (sch_ready)
  );

  assign mem_cs_n   = pin_cmd.cs_n;
  assign mem_ras_n  = pin_cmd.ras_n;
  assign mem_cas_n  = pin_cmd.cas_n;
  assign mem_we_n   = pin_cmd.we_n;
  assign pwr_state  = st;
  assign pd_timeout = force_exit;

endmodule

// File: rtl/cke_seq_chk.sv
module cke_seq_chk #(
  parameter int unsigned FORCE_AT = 56
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_enter_req,
  input logic       any_bank_open,
  input logic       burst_busy,
  input logic       sch_ready,
  input logic       mem_cke,
  input logic       mem_cs_n,
  input logic       mem_ras_n,
  input logic       mem_cas_n,
  input logic       mem_we_n,
  input logic [1:0] pwr_state,
  input logic       pd_timeout
);

  logic [3:0]  pins;
  int unsigned pd_run;

  assign pins = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

  always_ff @(posedge clk) begin
    if (!rst_n) pd_run <= 0;
    else if (pwr_state == 2'b01) pd_run <= pd_run + 1;
    else pd_run <= 0;
  end

  // R6
  pd_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01) |-> (pins == 4'b1111 && !sch_ready && !mem_cke));

  // R7
  susp_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10) |-> (pins == 4'b0111 && !sch_ready && !mem_cke));

  // R8
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b11) |-> (pins == 4'b0111 && !sch_ready && mem_cke));

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && lp_enter_req && !any_bank_open && burst_busy)
      |=> (pwr_state == 2'b00 && mem_cke));

  // R9
  residency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_run <= FORCE_AT);

  // R9
  timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_timeout |=> (pwr_state == 2'b11));

  // R10
  pd_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01) |=> (pwr_state == 2'b01 || pwr_state == 2'b11));

endmodule

bind cke_power_seq cke_seq_chk #(.FORCE_AT(FORCE_AT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lp_enter_req (lp_enter_req),
  .any_bank_open(any_bank_open),
  .burst_busy   (burst_busy),
  .sch_ready    (sch_ready),
  .mem_cke      (mem_cke),
  .mem_cs_n     (mem_cs_n),
  .mem_ras_n    (mem_ras_n),
  .mem_cas_n    (mem_cas_n),
  .mem_we_n     (mem_we_n),
  .pwr_state    (pwr_state),
  .pd_timeout   (pd_timeout)
);

// File: tb/sim_cke_power_seq.sv
`timescale 1ns/1ps
module sim_cke_power_seq;

  localparam int LIMIT = 64, MARGIN = 8, CKS = 2, CK = 1;
  localparam int RES_MAX  = LIMIT - MARGIN;
  localparam int WAKE_LEN = CKS + CK;

  logic clk = 0, rst_n = 0;
  logic enter = 0, leave = 0, bopen = 0, busy = 0;
  logic [3:0] scmd = 4'b1111;
  logic sch_ready, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, pd_timeout;
  logic [1:0] pwr_state;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cke_power_seq #(.REF_LIMIT(LIMIT), .REF_MARGIN(MARGIN), .CKS_CYC(CKS), .CK_CYC(CK)) u0 (
    .clk(clk), .rst_n(rst_n), .lp_enter_req(enter), .lp_exit_req(leave),
    .any_bank_open(bopen), .burst_busy(busy),
    .sch_cs_n(scmd[3]), .sch_ras_n(scmd[2]), .sch_cas_n(scmd[1]), .sch_we_n(scmd[0]),
    .sch_ready(sch_ready), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .pwr_state(pwr_state), .pd_timeout(pd_timeout));

  // observed word: {state[1:0], cke, cs, ras, cas, we, ready}
  function automatic logic [7:0] obs();
    return {pwr_state, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, sch_ready};
  endfunction

  function automatic logic [7:0] want(logic [1:0] s, logic k, logic [3:0] c, logic r);
    return {s, k, c, r};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expects power-down already requested to leave; checks the wake window
  task automatic wake_window(string req, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      leave = 0;
      check(req, obs(), want(2'b11, 1'b1, 4'b0111, 1'b0));
    end
    @(negedge clk);
    check(req, obs(), want(2'b00, 1'b1, scmd, 1'b1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", obs(), want(2'b00, 1'b1, scmd, 1'b1));
  endtask

  task automatic t_passthrough();
    scmd = 4'b0011; #1;
    check("R2", obs(), want(2'b00, 1'b1, 4'b0011, 1'b1));
    scmd = 4'b0100; #1;
    check("R2", obs(), want(2'b00, 1'b1, 4'b0100, 1'b1));
  endtask

  task automatic t_pdown();
    @(negedge clk);
    bopen = 0; busy = 0; enter = 1; scmd = 4'b0011; #1;
    check("R3 accept", obs(), want(2'b00, 1'b1, 4'b0111, 1'b0));
    @(negedge clk);
    enter = 0;
    check("R3 entered", obs(), want(2'b01, 1'b0, 4'b1111, 1'b0));
    for (int i = 0; i < 3; i++) begin
      scmd = 4'(i); #1;
      check("R6", obs(), want(2'b01, 1'b0, 4'b1111, 1'b0));
      @(negedge clk);
    end
    bopen = 1; enter = 1;
    @(negedge clk);
    enter = 0; bopen = 0;
    check("R10", obs(), want(2'b01, 1'b0, 4'b1111, 1'b0));
    scmd = 4'b0101; leave = 1;
    wake_window("R8", WAKE_LEN);
  endtask

  task automatic t_suspend();
    @(negedge clk);
    bopen = 1; busy = 1; enter = 1;
    @(negedge clk);
    enter = 0; scmd = 4'b0010;
    check("R4", obs(), want(2'b10, 1'b0, 4'b0111, 1'b0));
    @(negedge clk);
    check("R7 ignored cmd", obs(), want(2'b10, 1'b0, 4'b0111, 1'b0));
    leave = 1;
    wake_window("R7", 1);
    busy = 0; bopen = 0;
  endtask

  task automatic t_blocked();
    @(negedge clk);
    bopen = 0; busy = 1; enter = 1; scmd = 4'b0110;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R5", obs(), want(2'b00, 1'b1, 4'b0110, 1'b1));
    end
    enter = 0; busy = 0;
  endtask

  task automatic t_forced();
    int pd_cycles = 0, pulse_at = -1;
    @(negedge clk);
    bopen = 0; busy = 0; enter = 1;
    @(negedge clk);
    enter = 0;
    while (pwr_state == 2'b01 && pd_cycles < 500) begin
      if (pd_timeout) pulse_at = pd_cycles;
      pd_cycles++;
      @(negedge clk);
    end
    check_int("R9 residency", pd_cycles, RES_MAX);
    check_int("R9 pulse cycle", pulse_at, RES_MAX - 1);
    check("R9 exit", obs(), want(2'b11, 1'b1, 4'b0111, 1'b0));
    wake_window("R9 wake", WAKE_LEN - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_passthrough();
    t_pdown();
    t_suspend();
    t_blocked();
    t_forced();
    t_passthrough();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule